// File: doc/BRIEF.md
# Shift-Only Chaotic Oscillator Random Symbol Generator

This block integrates a third-order "jerk" chaotic system in fixed-point hardware. It holds three state registers, X, Y and Z. Each is a 16-bit signed two's-complement word with a sign bit, three integer bits and twelve fraction bits. On every enabled clock the block advances the three states by one forward-Euler step. The step size is a power of two, 2^-SHIFT_H. The nonlinear damping gain is also a power of two, 2^SHIFT_G. Because of this, every product in the update reduces to an arithmetic shift.

The nonlinear term is piecewise constant. It adds the gain times Y only while Y is at or above 1.0. Otherwise it contributes zero.

Software or a neighbouring block seeds the three states through a load strobe, then pulses or holds the step enable. The raw states are available on the outputs. A 9-bit random symbol is also produced. It is built from three low-order bits of each state, skipping bit 0 and all high-order bits, and is flagged valid in the cycle after each step.

Top module: `chaos_rng`

## Requirements
- R1: While rst_n is low, x_o, y_o and z_o are 0 and sym_vld_o is 0.
- R2: When load_i is high at a clock edge, the states take seed_x_i, seed_y_i and seed_z_i, whatever step_i is.
- R3: When neither load_i nor step_i is high at a clock edge, the three states keep their values.
- R4: On a step, the new X is X + (Y >>> 6), using the old state values.
- R5: On a step, the new Y is Y + (Z >>> 6), using the old state values.
- R6: On a step, the new Z is Z - ((Z + G + X) >>> 6), where G is the gated nonlinear term. G is active only when Y[15] is 0 and at least one of Y[14:12] is 1, that is, when Y ≥ 1.0 (4096).
- R7: When the gate of R6 is active, G equals Y shifted left by 1 (gain 2), truncated to 16 bits. When the gate is inactive, G is 0.
- R8: All sums wrap modulo 2^16, and every right shift copies the sign bit.
- R9: sym_o is {X[3:1], Y[3:1], Z[3:1]}, with X in bits 8:6 and Z in bits 2:0.
- R10: sym_vld_o is 1 in exactly the cycles following an edge at which a step was taken (step_i high and load_i low).
- R11: A loaded all-zero state stays all-zero under any number of steps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| load_i | input | 1 | Seed strobe; overrides step_i |
| seed_x_i | input | 16 | Initial X value |
| seed_y_i | input | 16 | Initial Y value |
| seed_z_i | input | 16 | Initial Z value |
| step_i | input | 1 | Advance one integration step |
| x_o | output | 16 | X state |
| y_o | output | 16 | Y state |
| z_o | output | 16 | Z state |
| sym_o | output | 9 | Random symbol |
| sym_vld_o | output | 1 | Symbol valid, one cycle after a step |

## Verification
The main stimulus is a long chaotic run of several thousand steps from a nonzero seed, with the enable held high. A model compares all three states after every step, which separates errors in any one of the three update equations.

A second run drops the enable on a fixed pattern. This separates step counting from holding. Load and step are also asserted in the same cycle to expose priority errors.

Single-step cases from hand-picked seeds cover the remaining boundaries:
- Y equal to 4096 and Y equal to 4095 show the gate threshold.
- A negative Y shows sign extension.
- A near-full-scale X and Y show 16-bit wrap.
- An all-zero load shows the fixed point.

// File: rtl/chaos_pkg.sv
package chaos_pkg;
  localparam int unsigned FX_W = 16;
  localparam int unsigned FX_INT = 3;
  localparam int unsigned FX_FRAC = FX_W - 1 - FX_INT;

  typedef logic signed [FX_W-1:0] fx_t;

  typedef struct packed {
    fx_t x;
    fx_t y;
    fx_t z;
  } state_t;
endpackage

// File: rtl/chaos_nonlin.sv
module chaos_nonlin #(
  parameter int unsigned DW       = 16,
  parameter int unsigned INT_BITS = 3,
  parameter int unsigned SHIFT_G  = 1
) (
  input  logic signed [DW-1:0] y_i,
  output logic signed [DW-1:0] term_o,
  output logic                 gate_o
);
  logic signed [DW-1:0] gained;

  // Y >= 1.0: non-negative and at least one integer bit set
  assign gate_o = ~y_i[DW-1] & (|y_i[DW-2 -: INT_BITS]);
  assign gained = y_i <<< SHIFT_G;
  assign term_o = gained & {DW{gate_o}};
endmodule

// File: rtl/chaos_csa3.sv
module chaos_csa3 #(
  parameter int unsigned DW = 16
) (
  input  logic signed [DW-1:0] a_i,
  input  logic signed [DW-1:0] b_i,
  input  logic signed [DW-1:0] c_i,
  output logic signed [DW-1:0] sum_o
);
  logic [DW-1:0] ps;
  logic [DW-1:0] pc;

  for (genvar i = 0; i < DW; i++) begin : g_fa
    assign ps[i] = a_i[i] ^ b_i[i] ^ c_i[i];
    assign pc[i] = (a_i[i] & b_i[i]) | (a_i[i] & c_i[i]) | (b_i[i] & c_i[i]);
  end

  // single carry-propagate stage resolves the redundant pair
  assign sum_o = $signed(ps + {pc[DW-2:0], 1'b0});
endmodule

// File: rtl/chaos_rng.sv
module chaos_rng #(
  parameter int unsigned DW       = 16,
  parameter int unsigned INT_BITS = 3,
  parameter int unsigned SHIFT_H  = 6,
  parameter int unsigned SHIFT_G  = 1,
  parameter int unsigned SYM_LO   = 1,
  parameter int unsigned SYM_PER  = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load_i,
  input  logic signed [DW-1:0]      seed_x_i,
  input  logic signed [DW-1:0]      seed_y_i,
  input  logic signed [DW-1:0]      seed_z_i,
  input  logic                      step_i,
  output logic signed [DW-1:0]      x_o,
  output logic signed [DW-1:0]      y_o,
  output logic signed [DW-1:0]      z_o,
  output logic [3*SYM_PER-1:0]      sym_o,
  output logic                      sym_vld_o
);
  localparam int unsigned SYM_HI = SYM_LO + SYM_PER - 1;

  logic signed [DW-1:0] x_q, y_q, z_q;
  logic signed [DW-1:0] x_d, y_d, z_d;
  logic                 vld_q, vld_d;
  logic                 st_en;
  logic signed [DW-1:0] nl_term;
  logic                 nl_gate;
  logic signed [DW-1:0] z_sum;

  chaos_nonlin #(
    .DW       (DW),
    .INT_BITS (INT_BITS),
    .SHIFT_G  (SHIFT_G)
  ) u_nonlin (
    .y_i    (y_q),
    .term_o (nl_term),
    .gate_o (nl_gate)
  );

  chaos_csa3 #(
    .DW (DW)
  ) u_zsum (
    .a_i   (z_q),
    .b_i   (nl_term),
    .c_i   (x_q),
    .sum_o (z_sum)
  );

  assign st_en = load_i | step_i;

  always_comb begin
    x_d   = x_q;
    y_d   = y_q;
    z_d   = z_q;
    vld_d = 1'b0;
    if (load_i) begin
      x_d = seed_x_i;
      y_d = seed_y_i;
      z_d = seed_z_i;
    end else if (step_i) begin
      x_d   = x_q + (y_q >>> SHIFT_H);
      y_d   = y_q + (z_q >>> SHIFT_H);
      z_d   = z_q - (z_sum >>> SHIFT_H);
      vld_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= '0;
      y_q <= '0;
      z_q <= '0;
    end else if (st_en) begin
      x_q <= x_d;
      y_q <= y_d;
      z_q <= z_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
    end
  end

  assign x_o       = x_q;
  assign y_o       = y_q;
  assign z_o       = z_q;
  assign sym_o     = {x_q[SYM_HI:SYM_LO], y_q[SYM_HI:SYM_LO], z_q[SYM_HI:SYM_LO]};
  assign sym_vld_o = vld_q;
endmodule

// File: rtl/chaos_rng_chk.sv
module chaos_rng_chk #(
  parameter int unsigned DW       = 16,
  parameter int unsigned INT_BITS = 3,
  parameter int unsigned SHIFT_H  = 6
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 load_i,
  input logic signed [DW-1:0] seed_x_i,
  input logic signed [DW-1:0] seed_y_i,
  input logic signed [DW-1:0] seed_z_i,
  input logic                 step_i,
  input logic signed [DW-1:0] x_o,
  input logic signed [DW-1:0] y_o,
  input logic signed [DW-1:0] z_o,
  input logic                 sym_vld_o
);
  localparam int unsigned FRAC = DW - 1 - INT_BITS;
  localparam logic signed [DW-1:0] ONE_FX = DW'(1) << FRAC;

  logic                 took_step;
  logic signed [DW-1:0] x_exp, y_exp, zlin_sum, zlin_exp;

  assign took_step = step_i & ~load_i;
  assign x_exp     = x_o + (y_o >>> SHIFT_H);
  assign y_exp     = y_o + (z_o >>> SHIFT_H);
  assign zlin_sum  = z_o + x_o;
  assign zlin_exp  = z_o - (zlin_sum >>> SHIFT_H);

  always_comb begin
    if (!rst_n) begin
      AST_RESET_CLEAR: assert (x_o == '0 && y_o == '0 && z_o == '0 && !sym_vld_o); // R1
    end
  end

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (x_o == $past(seed_x_i) && y_o == $past(seed_y_i) && z_o == $past(seed_z_i))); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !step_i) |=> ($stable(x_o) && $stable(y_o) && $stable(z_o))); // R3

  AST_X_EULER: assert property (@(posedge clk) disable iff (!rst_n)
    took_step |=> x_o == $past(x_exp)); // R4

  AST_Y_EULER: assert property (@(posedge clk) disable iff (!rst_n)
    took_step |=> y_o == $past(y_exp)); // R5

  AST_Z_GATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (took_step && y_o < ONE_FX) |=> z_o == $past(zlin_exp)); // R6

  AST_VLD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    took_step |=> sym_vld_o); // R10

  AST_VLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !took_step |=> !sym_vld_o); // R10

  AST_ZERO_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (took_step && x_o == '0 && y_o == '0 && z_o == '0) |=> (x_o == '0 && y_o == '0 && z_o == '0)); // R11
endmodule

bind chaos_rng chaos_rng_chk #(
  .DW       (DW),
  .INT_BITS (INT_BITS),
  .SHIFT_H  (SHIFT_H)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .load_i    (load_i),
  .seed_x_i  (seed_x_i),
  .seed_y_i  (seed_y_i),
  .seed_z_i  (seed_z_i),
  .step_i    (step_i),
  .x_o       (x_o),
  .y_o       (y_o),
  .z_o       (z_o),
  .sym_vld_o (sym_vld_o)
);

// File: tb/chaos_rng_tb.sv
`timescale 1ns/1ps
module chaos_rng_tb;
  localparam int A = 6;
  localparam int GAIN = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load_i = 1'b0;
  logic step_i = 1'b0;
  logic signed [15:0] seed_x_i = '0, seed_y_i = '0, seed_z_i = '0;
  logic signed [15:0] x_o, y_o, z_o;
  logic [8:0] sym_o;
  logic sym_vld_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int mx = 0, my = 0, mz = 0, mv = 0;

  always #2 clk = ~clk;

  chaos_rng u_dut (
    .clk(clk), .rst_n(rst_n), .load_i(load_i),
    .seed_x_i(seed_x_i), .seed_y_i(seed_y_i), .seed_z_i(seed_z_i),
    .step_i(step_i), .x_o(x_o), .y_o(y_o), .z_o(z_o),
    .sym_o(sym_o), .sym_vld_o(sym_vld_o)
  );

  function automatic int w16(input int v);
    logic [15:0] t;
    t = v[15:0];
    return int'($signed(t));
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int sym_exp;
    sym_exp = (((mx >> 1) & 7) << 6) | (((my >> 1) & 7) << 3) | ((mz >> 1) & 7);
    chk("R4 x", int'(x_o), mx);
    chk("R5 y", int'(y_o), my);
    chk("R6 z", int'(z_o), mz);
    chk("R9 sym", int'(sym_o), sym_exp);
    chk("R10 vld", int'(sym_vld_o), mv);
  endtask

  task automatic cyc(input bit ld, input int sx, input int sy, input int sz, input bit st);
    int nx, ny, nz, g, s;
    load_i = ld;
    seed_x_i = 16'(sx);
    seed_y_i = 16'(sy);
    seed_z_i = 16'(sz);
    step_i = st;
    @(posedge clk);
    if (ld) begin
      mx = w16(sx); my = w16(sy); mz = w16(sz); mv = 0;
    end else if (st) begin
      g  = (my >= 4096) ? w16(my * GAIN) : 0;
      s  = w16(mz + g + mx);
      nx = w16(mx + (my >>> A));
      ny = w16(my + (mz >>> A));
      nz = w16(mz - (s >>> A));
      mx = nx; my = ny; mz = nz; mv = 1;
    end else begin
      mv = 0;
    end
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    #(800000);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 x", int'(x_o), 0);
    chk("R1 y", int'(y_o), 0);
    chk("R1 z", int'(z_o), 0);
    chk("R1 vld", int'(sym_vld_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 load wins over a simultaneous step
    cyc(1, 16'h0400, 16'h0200, -16'sd300, 1);
    chk("R2 x", int'(x_o), 1024);
    chk("R2 vld", int'(sym_vld_o), 0);

    // R3 idle holds
    cyc(0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);
    chk("R3 y", int'(y_o), 512);

    // long chaotic run, enable always high
    for (int i = 0; i < 4000; i++) cyc(0, 0, 0, 0, 1);

    // enable pattern with gaps
    for (int i = 0; i < 1500; i++) cyc(0, 0, 0, 0, (i % 3) != 0);

    // R6/R7 gate boundary: Y exactly 1.0
    cyc(1, 0, 4096, 0, 0);
    cyc(0, 0, 0, 0, 1);
    chk("R7 z gate on", int'(z_o), -128);
    // just below 1.0
    cyc(1, 0, 4095, 0, 0);
    cyc(0, 0, 0, 0, 1);
    chk("R6 z gate off", int'(z_o), 0);
    chk("R4 x", int'(x_o), 63);
    // R8 negative Y: sign extension and gate off
    cyc(1, 0, -4096, 0, 0);
    cyc(0, 0, 0, 0, 1);
    chk("R8 x signext", int'(x_o), -64);
    chk("R6 z neg", int'(z_o), 0);
    // R8 wrap near full scale
    cyc(1, 32767, 32767, 0, 0);
    cyc(0, 0, 0, 0, 1);
    chk("R8 x wrap", int'(x_o), -32258);

    // R11 zero fixed point
    cyc(1, 0, 0, 0, 0);
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, 0, 1);
    chk("R11 x", int'(x_o), 0);
    chk("R11 y", int'(y_o), 0);
    chk("R11 z", int'(z_o), 0);

    // second seed, load and step together again
    cyc(1, -16'sd2000, 16'sd5000, 16'sd1234, 1);
    for (int i = 0; i < 2000; i++) cyc(0, 0, 0, 0, 1);

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule